// File: doc/BRIEF.md
# Delay-Slot Writeback Scheduler

This block handles result timing for a single-issue pipeline whose delay slots are visible to the program. Each clock it may take one issued operation: an operation class, a destination register number, the already computed result value (or branch target) and an optional predicate. The predicate is tested at issue. An operation that passes is held in a delay line set by its class. When the fixed delay runs out, the block presents the write to the register file, or for a branch a redirect pulse that carries the target.

The block never stalls. Every class accepts a new operation on every cycle, however many results are still pending, so several results may be in flight at once. Until a delayed write lands, the register keeps its old value and later operations read that stale value; the program is expected to allow for this. Arithmetic, multiply and load results each have their own write port. If results from more than one class fall due in the same cycle for the same destination, only the operation issued most recently writes.

Top module: `wbs_sched`

## Requirements
- R1: An issued operation of class 0 (add/subtract/move) appears on write port 0 (`wr_en[0]`, `wr_dst[4:0]`, `wr_data[31:0]`) in the cycle right after its issue edge (0 delay slots), for one cycle.
- R2: An operation of class 1 (multiply) appears on write port 1 (`wr_en[1]`, `wr_dst[9:5]`, `wr_data[63:32]`) one cycle later than a class-0 result would (1 delay slot).
- R3: An operation of class 2 (load) appears on write port 2 (`wr_en[2]`, `wr_dst[14:10]`, `wr_data[95:64]`) four cycles later than a class-0 result would (4 delay slots).
- R4: An operation of class 3 (branch) raises `redir_valid` for exactly one cycle, with `iss_value` on `redir_target`, five cycles later than a class-0 result would (5 delay slots). It causes no register write.
- R5: Destination and value are captured at the issue edge. Later changes on `iss_dst` and `iss_value` do not alter the pending result.
- R6: A new operation is accepted on every cycle, and results of different classes issued on consecutive cycles each emerge at their own due cycle, including several in the same cycle on different ports.
- R7: With `iss_pred_en` high, `iss_pred_sel` values 0 to 4 pick bit 0 to 4 of `cond_nz`. The operation executes when that bit is 1 and `iss_pred_inv` is 0, or when the bit is 0 and `iss_pred_inv` is 1. With `iss_pred_en` low it always executes.
- R8: An operation whose predicate fails produces no write on any port and no redirect.
- R9: When writes from two or more ports fall due in the same cycle with the same destination, only the lowest-numbered port keeps its enable (this is the latest issued, because the delays rise with the port number). The others are dropped.
- R10: With `iss_pred_en` high, `iss_pred_sel` values 5 to 7 name no condition register, and the operation is squashed whatever the value of `iss_pred_inv`.
- R11: While `rst_n` is low, all write enables and `redir_valid` are low, and any operation in flight when reset is asserted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An operation is issued this cycle |
| iss_class | input | 2 | 0 arithmetic/move, 1 multiply, 2 load, 3 branch |
| iss_dst | input | 5 | Destination register number |
| iss_value | input | 32 | Result value, or branch target |
| iss_pred_en | input | 1 | Operation is predicated |
| iss_pred_sel | input | 3 | Condition register index (0 to 4) |
| iss_pred_inv | input | 1 | Execute when the selected register is zero |
| cond_nz | input | 5 | Nonzero flag of each condition register |
| wr_en | output | 3 | Write enable per class port |
| wr_dst | output | 15 | Destination per port, 5 bits each |
| wr_data | output | 96 | Write data per port, 32 bits each |
| redir_valid | output | 1 | Branch takes effect this cycle |
| redir_target | output | 32 | Branch target address |

## Verification
The bench builds the block with its default parameters: 32-bit data, 5-bit register numbers, five condition registers and delays of 0, 1, 4 and 5 slots. With these delays the ports really overlap. A load, then a multiply, then an add issued back to back land two results in one cycle. A load, a multiply three cycles after it and an add one cycle after that all fall due together on one register, which exercises the three-way priority. The five-entry condition set, addressed by a 3-bit selector, leaves three unused selector codes for the squash case.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_MUL    = 2'd1,
    CLS_LOAD   = 2'd2,
    CLS_BRANCH = 2'd3
  } op_class_e;

  // classes that end in a register write, one port each
  localparam int unsigned NUM_WB_CLASSES = 3;

endpackage

// File: rtl/wbs_pred_eval.sv
module wbs_pred_eval #(
  parameter int unsigned NUM_COND = 5,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                pred_en,
  input  logic [SEL_W-1:0]    pred_sel,
  input  logic                pred_inv,
  input  logic [NUM_COND-1:0] cond_nz,
  output logic                go
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_COND - 1);

  always_comb begin
    if (!pred_en) begin
      go = 1'b1;
    end else if (pred_sel <= LAST_SEL) begin
      go = cond_nz[pred_sel] ^ pred_inv;
    end else begin
      go = 1'b0;
    end
  end

endmodule

// File: rtl/wbs_delay_line.sv
module wbs_delay_line #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_data
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [WIDTH-1:0] dat_q [DEPTH];
  logic [WIDTH-1:0] dat_d [DEPTH];

  // next state: the top stage takes the new entry, every other stage the one above
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == DEPTH - 1) begin : g_top
      assign vld_d[s] = in_vld;
      assign dat_d[s] = in_data;
    end else begin : g_mid
      assign vld_d[s] = vld_q[s+1];
      assign dat_d[s] = dat_q[s+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // payload has no reset, loaded only when a valid entry moves in
  always_ff @(posedge clk) begin
    for (int s = 0; s < int'(DEPTH); s++) begin
      if (vld_d[s]) begin
        dat_q[s] <= dat_d[s];
      end
    end
  end

  assign out_vld  = vld_q[0];
  assign out_data = dat_q[0];

  for (genvar s = 1; s < DEPTH; s++) begin : g_chk
    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[s] |=> vld_q[s-1]); // R6
  end

endmodule

// File: rtl/wbs_wr_merge.sv
module wbs_wr_merge #(
  parameter int unsigned PORTS = 3,
  parameter int unsigned REG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS-1:0]       in_en,
  input  logic [PORTS*REG_W-1:0] in_dst,
  output logic [PORTS-1:0]       out_en
);

  logic [PORTS-1:0] shadow;

  // a port is shadowed when a lower (later-issued) port writes the same register
  always_comb begin
    for (int i = 0; i < int'(PORTS); i++) begin
      shadow[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (in_en[j] && (in_dst[j*REG_W +: REG_W] == in_dst[i*REG_W +: REG_W])) begin
          shadow[i] = 1'b1;
        end
      end
    end
  end

  assign out_en = in_en & ~shadow;

  for (genvar i = 0; i < PORTS; i++) begin : g_pi
    for (genvar j = i + 1; j < PORTS; j++) begin : g_pj
      AST_UNIQUE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en[i] && out_en[j]) |-> (in_dst[i*REG_W +: REG_W] != in_dst[j*REG_W +: REG_W])); // R9
    end
  end

endmodule

// File: rtl/wbs_sched.sv
module wbs_sched
  import wbs_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned REG_W        = 5,
  parameter int unsigned NUM_COND     = 5,
  parameter int unsigned ALU_SLOTS    = 0,
  parameter int unsigned MUL_SLOTS    = 1,
  parameter int unsigned LOAD_SLOTS   = 4,
  parameter int unsigned BRANCH_SLOTS = 5,
  localparam int unsigned SEL_W       = $clog2(NUM_COND),
  localparam int unsigned WB_PORTS    = NUM_WB_CLASSES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [1:0]                iss_class,
  input  logic [REG_W-1:0]          iss_dst,
  input  logic [DATA_W-1:0]         iss_value,
  input  logic                      iss_pred_en,
  input  logic [SEL_W-1:0]          iss_pred_sel,
  input  logic                      iss_pred_inv,
  input  logic [NUM_COND-1:0]       cond_nz,
  output logic [WB_PORTS-1:0]       wr_en,
  output logic [WB_PORTS*REG_W-1:0] wr_dst,
  output logic [WB_PORTS*DATA_W-1:0] wr_data,
  output logic                      redir_valid,
  output logic [DATA_W-1:0]         redir_target
);

  localparam int unsigned ENTRY_W = REG_W + DATA_W;

  function automatic int unsigned slots_of(int unsigned idx);
    case (idx)
      0:       return ALU_SLOTS;
      1:       return MUL_SLOTS;
      default: return LOAD_SLOTS;
    endcase
  endfunction

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe_q[1];

  // predicate test at issue
  logic go;
  logic accept;

  wbs_pred_eval #(
    .NUM_COND (NUM_COND),
    .SEL_W    (SEL_W)
  ) u_pred (
    .pred_en  (iss_pred_en),
    .pred_sel (iss_pred_sel),
    .pred_inv (iss_pred_inv),
    .cond_nz  (cond_nz),
    .go       (go)
  );

  assign accept = iss_valid && go;

  // one delay line per writing class
  logic [WB_PORTS-1:0] raw_en;

  for (genvar g = 0; g < WB_PORTS; g++) begin : g_cls
    logic               line_in_vld;
    logic [ENTRY_W-1:0] line_out;

    assign line_in_vld = accept && (iss_class == 2'(g));

    wbs_delay_line #(
      .DEPTH (slots_of(g) + 1),
      .WIDTH (ENTRY_W)
    ) u_line (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .in_vld   (line_in_vld),
      .in_data  ({iss_dst, iss_value}),
      .out_vld  (raw_en[g]),
      .out_data (line_out)
    );

    assign wr_dst[g*REG_W +: REG_W]    = line_out[ENTRY_W-1 -: REG_W];
    assign wr_data[g*DATA_W +: DATA_W] = line_out[DATA_W-1:0];
  end

  // branch target line
  logic br_in_vld;

  assign br_in_vld = accept && (iss_class == CLS_BRANCH);

  wbs_delay_line #(
    .DEPTH (BRANCH_SLOTS + 1),
    .WIDTH (DATA_W)
  ) u_br_line (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .in_vld   (br_in_vld),
    .in_data  (iss_value),
    .out_vld  (redir_valid),
    .out_data (redir_target)
  );

  // same-register collisions: the later issue wins
  wbs_wr_merge #(
    .PORTS (WB_PORTS),
    .REG_W (REG_W)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .in_en  (raw_en),
    .in_dst (wr_dst),
    .out_en (wr_en)
  );

  AST_ALU_NEXT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n && iss_valid && go && (iss_class == CLS_ALU)) |->
      (wr_en[0] && (wr_data[DATA_W-1:0] == $past(iss_value))
                && (wr_dst[REG_W-1:0] == $past(iss_dst)))); // R1

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n && iss_valid && !go && (iss_class == CLS_ALU)) |-> !wr_en[0]); // R8

endmodule

// File: tb/sim_wbs_sched.sv
module sim_wbs_sched;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  cls;
    logic [4:0]  dst;
    logic [31:0] val;
    logic        pen;
    logic [2:0]  sel;
    logic        inv;
    logic [4:0]  cond;
    logic        fire;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 5'd3,  32'h1111_0001, 1'b0, 3'd0, 1'b0, 5'b00000, 1'b1}, // R1
    '{2'd1, 5'd4,  32'h2222_0002, 1'b0, 3'd0, 1'b0, 5'b00000, 1'b1}, // R2
    '{2'd2, 5'd5,  32'h3333_0003, 1'b0, 3'd0, 1'b0, 5'b00000, 1'b1}, // R3
    '{2'd3, 5'd0,  32'h0000_0104, 1'b0, 3'd0, 1'b0, 5'b00000, 1'b1}, // R4
    '{2'd0, 5'd8,  32'h4444_0004, 1'b1, 3'd0, 1'b0, 5'b00001, 1'b1}, // R7
    '{2'd0, 5'd8,  32'h5555_0005, 1'b1, 3'd0, 1'b0, 5'b00000, 1'b0}, // R8
    '{2'd2, 5'd9,  32'h6666_0006, 1'b1, 3'd4, 1'b1, 5'b00000, 1'b1}, // R7
    '{2'd2, 5'd9,  32'h7777_0007, 1'b1, 3'd4, 1'b1, 5'b10000, 1'b0}, // R8
    '{2'd3, 5'd0,  32'h0000_0200, 1'b1, 3'd2, 1'b0, 5'b11011, 1'b0}, // R8
    '{2'd1, 5'd13, 32'h8888_0008, 1'b1, 3'd6, 1'b1, 5'b11111, 1'b0}, // R10
    '{2'd1, 5'd14, 32'h9999_0009, 1'b1, 3'd3, 1'b1, 5'b10111, 1'b1}  // R7
  };

  logic        clk;
  logic        rst_n;
  logic        iss_valid;
  logic [1:0]  iss_class;
  logic [4:0]  iss_dst;
  logic [31:0] iss_value;
  logic        iss_pred_en;
  logic [2:0]  iss_pred_sel;
  logic        iss_pred_inv;
  logic [4:0]  cond_nz;
  logic [2:0]  wr_en;
  logic [14:0] wr_dst;
  logic [95:0] wr_data;
  logic        redir_valid;
  logic [31:0] redir_target;

  int n_chk  = 0;
  int n_fail = 0;

  wbs_sched u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_class    (iss_class),
    .iss_dst      (iss_dst),
    .iss_value    (iss_value),
    .iss_pred_en  (iss_pred_en),
    .iss_pred_sel (iss_pred_sel),
    .iss_pred_inv (iss_pred_inv),
    .cond_nz      (cond_nz),
    .wr_en        (wr_en),
    .wr_dst       (wr_dst),
    .wr_data      (wr_data),
    .redir_valid  (redir_valid),
    .redir_target (redir_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(vec_t v);
    if (!v.fire) return (v.sel > 3'd4) ? "R10" : "R8";
    if (v.pen) return "R7";
    case (v.cls)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic int due_of(int p);
    case (p)
      0:       return 0;
      1:       return 1;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

  task automatic drive(input logic [1:0] c, input logic [4:0] d, input logic [31:0] v);
    iss_valid    = 1'b1;
    iss_class    = c;
    iss_dst      = d;
    iss_value    = v;
    iss_pred_en  = 1'b0;
    iss_pred_sel = 3'd0;
    iss_pred_inv = 1'b0;
  endtask

  task automatic idle();
    iss_valid = 1'b0;
    iss_value = 32'hDEAD_BEEF;
    iss_dst   = 5'd31;
    cond_nz   = 5'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_class = 2'd0; iss_dst = 5'd0; iss_value = 32'd0;
    iss_pred_en = 1'b0; iss_pred_sel = 3'd0; iss_pred_inv = 1'b0; cond_nz = 5'd0;
    repeat (3) step();
    // R11: reset state
    check((wr_en == 3'b000) && !redir_valid, "R11 reset state",
          {wr_en, redir_valid}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) step();

    // vector table, one operation at a time
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      bit ok;
      logic [127:0] act;
      logic [127:0] exp;
      v = VECS[i];
      ok = 1'b1; act = '0; exp = '0;
      @(negedge clk);
      iss_valid = 1'b1; iss_class = v.cls; iss_dst = v.dst; iss_value = v.val;
      iss_pred_en = v.pen; iss_pred_sel = v.sel; iss_pred_inv = v.inv; cond_nz = v.cond;
      step();
      idle();
      for (int c = 0; c < 7; c++) begin
        for (int p = 0; p < 3; p++) begin
          bit e;
          e = v.fire && (int'(v.cls) == p) && (c == due_of(p));
          if (wr_en[p] != e) begin
            if (ok) begin act = {c[7:0], 5'(p), wr_en}; exp = {c[7:0], 5'(p), 3'(e) << p}; end
            ok = 1'b0;
          end else if (e && ((wr_dst[p*5 +: 5] != v.dst) || (wr_data[p*32 +: 32] != v.val))) begin
            if (ok) begin act = {wr_dst[p*5 +: 5], wr_data[p*32 +: 32]}; exp = {v.dst, v.val}; end
            ok = 1'b0;
          end
        end
        begin
          bit eb;
          eb = v.fire && (v.cls == 2'd3) && (c == due_of(3));
          if ((redir_valid != eb) || (eb && (redir_target != v.val))) begin
            if (ok) begin act = {c[7:0], redir_valid, redir_target}; exp = {c[7:0], eb, v.val}; end
            ok = 1'b0;
          end
        end
        if (c < 6) step();
      end
      check(ok, tag_of(v), act, exp);
    end

    // R6: load, multiply, add issued back to back
    @(negedge clk);
    drive(2'd2, 5'd10, 32'hA0A0_0010); step();
    drive(2'd1, 5'd11, 32'hB0B0_0011); step();
    drive(2'd0, 5'd12, 32'hC0C0_0012); step();
    idle();
    check((wr_en == 3'b011) && (wr_dst[9:0] == {5'd11, 5'd12}) &&
          (wr_data[63:0] == {32'hB0B0_0011, 32'hC0C0_0012}),
          "R6 two ports same cycle", {wr_en, wr_dst[9:0], wr_data[63:0]},
          {3'b011, 5'd11, 5'd12, 32'hB0B0_0011, 32'hC0C0_0012});
    step(); step();
    check((wr_en == 3'b100) && (wr_dst[14:10] == 5'd10) && (wr_data[95:64] == 32'hA0A0_0010),
          "R6 load lands after overlap", {wr_en, wr_dst[14:10], wr_data[95:64]},
          {3'b100, 5'd10, 32'hA0A0_0010});
    repeat (4) step();

    // R9: three writes due together on register 7
    drive(2'd2, 5'd7, 32'h0000_00AA); step();
    idle(); step(); step();
    drive(2'd1, 5'd7, 32'h0000_00BB); step();
    drive(2'd0, 5'd7, 32'h0000_00CC); step();
    idle();
    check((wr_en == 3'b001) && (wr_dst[4:0] == 5'd7) && (wr_data[31:0] == 32'h0000_00CC),
          "R9 latest issue wins", {wr_en, wr_dst[4:0], wr_data[31:0]},
          {3'b001, 5'd7, 32'h0000_00CC});
    repeat (4) step();

    // R5: inputs change after issue
    drive(2'd2, 5'd9, 32'h1234_5678); step();
    for (int k = 0; k < 4; k++) begin
      iss_valid = 1'b0;
      iss_dst   = 5'(k + 20);
      iss_value = 32'hFFFF_0000 + 32'(k);
      step();
    end
    idle();
    check((wr_en == 3'b100) && (wr_dst[14:10] == 5'd9) && (wr_data[95:64] == 32'h1234_5678),
          "R5 captured at issue", {wr_en, wr_dst[14:10], wr_data[95:64]},
          {3'b100, 5'd9, 32'h1234_5678});
    repeat (3) step();

    // R11: reset while a load and a branch are in flight
    drive(2'd2, 5'd6, 32'h0606_0606); step();
    drive(2'd3, 5'd0, 32'h0000_0300); step();
    idle(); step();
    rst_n = 1'b0;
    #1;
    begin
      bit quiet;
      quiet = (wr_en == 3'b000) && !redir_valid;
      step();
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if ((wr_en != 3'b000) || redir_valid) quiet = 1'b0;
        step();
      end
      check(quiet, "R11 in-flight discarded", {wr_en, redir_valid}, 4'b0000);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule